// File: doc/BRIEF.md
# Video Status and Interrupt Controller

This block keeps the status flags of a tile-based video controller and drives the processor's interrupt line. It watches the active line number and raises a frame flag when the line reaches the bottom of the visible picture. It also holds a frame-interrupt pending bit and a line-interrupt pending bit. The interrupt line is the registered OR of each pending bit ANDed with its enable. The two enables, and the picture height, come from two mode registers that are written through a register-write port.

A status read returns the flag byte, with the low five bits forced high. On the following clock edge it clears the flags, both pending bits and the control-port half-write flag, and this drops the interrupt line. A sprite collision that is scheduled at a later horizontal position on the current line is held back from a read and stays set for a later read. Writing a mode register while the matching interrupt is pending re-gates the interrupt line at once, according to the new enable bit.

Top module: `vsi_ctrl`

## Requirements
- R1: After reset, the status byte is 0x1F, the interrupt line is low, the half-write flag is low and the active height is 192.
- R2: A line-advance pulse whose line index equals the active height sets status bit 7 and the frame-pending bit. A line-advance pulse at any other index changes neither.
- R3: Status bits 4:0 always read as 1. Bit 6 is set by an overflow pulse. Bit 5 is set by a collision pulse. Both stay set until a status read.
- R4: The clock edge that ends a status read clears bits 7:5, both pending bits and the half-write flag. The interrupt line is low after that edge, unless a new event arrives in the read cycle.
- R5: The interrupt line is registered: irq = (frame pending AND mode-1 bit 5) OR (line pending AND mode-0 bit 4). A line-event pulse sets line pending.
- R6: Writing mode register 0 while a line interrupt is pending drives the interrupt line from bit 4 of the new value. Writing mode register 1 while a frame interrupt is pending drives it from bit 5 of the new value. In both cases the line changes from the next edge.
- R7: A collision pulse stores its line and horizontal position. While the current line equals the stored line and h_pos_i is below the stored position, bit 5 reads as 0. A read in that state leaves the collision flag set.
- R8: The mode value is {mode0[2], mode1[3], mode0[1], mode1[4]}. With EXT_MODES=1, value 0xB gives height 224 and 0xE gives 240. Every other value, or EXT_MODES=0, gives 192.
- R9: When a status read and a new frame, line, overflow or collision event fall in the same cycle, the read returns the old value and the new event stays set after the read.
- R10: A register write with an index other than 0 or 1 changes neither the height nor the interrupt enables.
- R11: A first-half control write pulse sets the half-write flag. A clear pulse or a status read clears it. When a set pulse arrives in the same cycle as a clear pulse, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_adv_i | input | 1 | Line counter has just advanced |
| line_idx_i | input | 9 | Current line index |
| h_pos_i | input | 8 | Current horizontal position |
| line_evt_i | input | 1 | Line-interrupt event pulse |
| ovr_evt_i | input | 1 | Sprite overflow pulse |
| coll_evt_i | input | 1 | Sprite collision pulse |
| coll_line_i | input | 9 | Line at which the collision takes effect |
| coll_x_i | input | 8 | Horizontal position at which the collision takes effect |
| reg_we_i | input | 1 | Register write strobe |
| reg_idx_i | input | 4 | Register index |
| reg_wdata_i | input | 8 | Register write value |
| rd_stat_i | input | 1 | Status read strobe |
| ctl_half_i | input | 1 | First half of a control-port write |
| ctl_clr_i | input | 1 | Data-port access, clears the half-write flag |
| status_o | output | 8 | Status byte, as a read would return it |
| irq_o | output | 1 | Interrupt line |
| ctl_pend_o | output | 1 | Half-write flag |
| act_h_o | output | 9 | Active display height |

## Verification
A status read can fall in the same cycle as a frame event, a line event or an overflow pulse. The clear on read then competes with the set from the event. The bench raises the read strobe together with a line-advance pulse at the height line, and separately together with a line-event pulse. It checks that the byte returned in that cycle shows the old flags, and that after the edge the new flag and the interrupt line are set. A mode-register write that re-gates a pending interrupt is also checked in the cycle that follows the write.

// File: rtl/vsi_pkg.sv
package vsi_pkg;

    localparam int LINE_W_D = 9;
    localparam int HPOS_W_D = 8;
    localparam int DATA_W_D = 8;
    localparam int IDX_W_D  = 4;
    localparam int LOW_W_D  = 5;

    // bit positions of the fields decoded from the two mode registers
    localparam int M0_M2_BIT   = 1;
    localparam int M0_M4_BIT   = 2;
    localparam int M0_LIE_BIT  = 4;
    localparam int M1_M3_BIT   = 3;
    localparam int M1_M1_BIT   = 4;
    localparam int M1_FIE_BIT  = 5;

    localparam logic [3:0] MODE_TALL  = 4'hB;
    localparam logic [3:0] MODE_TALLER = 4'hE;

    typedef enum logic [1:0] {
        HSEL_BASE  = 2'd0,
        HSEL_TALL  = 2'd1,
        HSEL_TALLER = 2'd2
    } vsi_hsel_e;

    typedef struct packed {
        logic line_ie;
        logic frm_ie;
        logic m4;
        logic m3;
        logic m2;
        logic m1;
    } vsi_mode_t;

    typedef struct packed {
        logic frame;
        logic ovr;
        logic coll;
    } vsi_flags_t;

    typedef struct packed {
        logic frm;
        logic lin;
    } vsi_pend_t;

    function automatic vsi_hsel_e pick_height(input vsi_mode_t m, input logic ext_ok);
        logic [3:0] code;
        code = {m.m4, m.m3, m.m2, m.m1};
        if (ext_ok && code == MODE_TALL)
            return HSEL_TALL;
        else if (ext_ok && code == MODE_TALLER)
            return HSEL_TALLER;
        return HSEL_BASE;
    endfunction

    function automatic logic [LINE_W_D-1:0] height_lines(input vsi_hsel_e h);
        case (h)
            HSEL_TALL:   return LINE_W_D'(224);
            HSEL_TALLER: return LINE_W_D'(240);
            default:     return LINE_W_D'(192);
        endcase
    endfunction

endpackage

// File: rtl/vsi_mode_regs.sv
module vsi_mode_regs
    import vsi_pkg::*;
#(
    parameter int  DATA_W    = DATA_W_D,
    parameter int  IDX_W     = IDX_W_D,
    parameter int  LINE_W    = LINE_W_D,
    parameter bit  EXT_MODES = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output vsi_mode_t         mode_q,
    output vsi_mode_t         mode_n,
    output logic [LINE_W-1:0] act_h
);

    localparam logic [IDX_W-1:0] IDX_M0 = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_M1 = IDX_W'(1);

    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[DATA_W-1:6], reg_wdata[0]};

    always_comb begin
        mode_n = mode_q;
        if (reg_we && reg_idx == IDX_M0) begin
            mode_n.m2      = reg_wdata[M0_M2_BIT];
            mode_n.m4      = reg_wdata[M0_M4_BIT];
            mode_n.line_ie = reg_wdata[M0_LIE_BIT];
        end else if (reg_we && reg_idx == IDX_M1) begin
            mode_n.m3      = reg_wdata[M1_M3_BIT];
            mode_n.m1      = reg_wdata[M1_M1_BIT];
            mode_n.frm_ie  = reg_wdata[M1_FIE_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else
            mode_q <= mode_n;
    end

    generate
        if (EXT_MODES) begin : g_ext
            assign act_h = LINE_W'(height_lines(pick_height(mode_q, 1'b1)));
        end else begin : g_base
            assign act_h = LINE_W'(height_lines(HSEL_BASE));
        end
    endgenerate

endmodule

// File: rtl/vsi_flag_bank.sv
module vsi_flag_bank
    import vsi_pkg::*;
#(
    parameter int LINE_W = LINE_W_D,
    parameter int HPOS_W = HPOS_W_D,
    parameter int LOW_W  = LOW_W_D,
    localparam int STAT_W = LOW_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_adv,
    input  logic [LINE_W-1:0] line_idx,
    input  logic [LINE_W-1:0] act_h,
    input  logic [HPOS_W-1:0] h_pos,
    input  logic              line_evt,
    input  logic              ovr_evt,
    input  logic              coll_evt,
    input  logic [LINE_W-1:0] coll_line,
    input  logic [HPOS_W-1:0] coll_x,
    input  logic              rd_stat,
    input  logic              ctl_half,
    input  logic              ctl_clr,
    output vsi_pend_t         pend_q,
    output vsi_pend_t         pend_n,
    output logic [STAT_W-1:0] status,
    output logic              ctl_pend
);

    vsi_flags_t        flags_q, flags_n;
    logic [LINE_W-1:0] cline_q;
    logic [HPOS_W-1:0] cx_q;
    logic              frame_hit;
    logic              coll_defer;
    logic              ctl_n;

    assign frame_hit  = line_adv && (line_idx == act_h);
    assign coll_defer = flags_q.coll && (line_idx == cline_q) && (h_pos < cx_q);

    always_comb begin
        if (rd_stat) begin
            // a read clears everything; events in the same cycle survive
            flags_n.frame = frame_hit;
            flags_n.ovr   = ovr_evt;
            flags_n.coll  = coll_evt || coll_defer;
            pend_n.frm    = frame_hit;
            pend_n.lin    = line_evt;
            ctl_n         = ctl_half;
        end else begin
            flags_n.frame = flags_q.frame || frame_hit;
            flags_n.ovr   = flags_q.ovr || ovr_evt;
            flags_n.coll  = flags_q.coll || coll_evt;
            pend_n.frm    = pend_q.frm || frame_hit;
            pend_n.lin    = pend_q.lin || line_evt;
            ctl_n         = ctl_half || (ctl_pend && !ctl_clr);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q  <= '0;
            pend_q   <= '0;
            ctl_pend <= 1'b0;
            cline_q  <= '0;
            cx_q     <= '0;
        end else begin
            flags_q  <= flags_n;
            pend_q   <= pend_n;
            ctl_pend <= ctl_n;
            if (coll_evt) begin
                cline_q <= coll_line;
                cx_q    <= coll_x;
            end
        end
    end

    assign status = {flags_q.frame, flags_q.ovr, flags_q.coll && !coll_defer, {LOW_W{1'b1}}};

endmodule

// File: rtl/vsi_irq_gate.sv
module vsi_irq_gate
    import vsi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  vsi_pend_t pend_n,
    input  vsi_mode_t mode_n,
    output logic      irq
);

    logic irq_d;

    assign irq_d = (pend_n.frm && mode_n.frm_ie) || (pend_n.lin && mode_n.line_ie);

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else
            irq <= irq_d;
    end

endmodule

// File: rtl/vsi_ctrl.sv
module vsi_ctrl
    import vsi_pkg::*;
#(
    parameter int LINE_W    = LINE_W_D,
    parameter int HPOS_W    = HPOS_W_D,
    parameter int DATA_W    = DATA_W_D,
    parameter int IDX_W     = IDX_W_D,
    parameter int LOW_W     = LOW_W_D,
    parameter bit EXT_MODES = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_adv_i,
    input  logic [LINE_W-1:0] line_idx_i,
    input  logic [HPOS_W-1:0] h_pos_i,
    input  logic              line_evt_i,
    input  logic              ovr_evt_i,
    input  logic              coll_evt_i,
    input  logic [LINE_W-1:0] coll_line_i,
    input  logic [HPOS_W-1:0] coll_x_i,
    input  logic              reg_we_i,
    input  logic [IDX_W-1:0]  reg_idx_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    input  logic              rd_stat_i,
    input  logic              ctl_half_i,
    input  logic              ctl_clr_i,
    output logic [LOW_W+2:0]  status_o,
    output logic              irq_o,
    output logic              ctl_pend_o,
    output logic [LINE_W-1:0] act_h_o
);

    vsi_mode_t mode_q, mode_n;
    vsi_pend_t pend_q, pend_n;
    logic      pend_frm_q, pend_lin_q, line_ie_q, frm_ie_q;

    vsi_mode_regs #(
        .DATA_W(DATA_W), .IDX_W(IDX_W), .LINE_W(LINE_W), .EXT_MODES(EXT_MODES)
    ) u_modes (
        .clk(clk), .rst(rst),
        .reg_we(reg_we_i), .reg_idx(reg_idx_i), .reg_wdata(reg_wdata_i),
        .mode_q(mode_q), .mode_n(mode_n), .act_h(act_h_o)
    );

    vsi_flag_bank #(
        .LINE_W(LINE_W), .HPOS_W(HPOS_W), .LOW_W(LOW_W)
    ) u_flags (
        .clk(clk), .rst(rst),
        .line_adv(line_adv_i), .line_idx(line_idx_i), .act_h(act_h_o),
        .h_pos(h_pos_i), .line_evt(line_evt_i), .ovr_evt(ovr_evt_i),
        .coll_evt(coll_evt_i), .coll_line(coll_line_i), .coll_x(coll_x_i),
        .rd_stat(rd_stat_i), .ctl_half(ctl_half_i), .ctl_clr(ctl_clr_i),
        .pend_q(pend_q), .pend_n(pend_n), .status(status_o), .ctl_pend(ctl_pend_o)
    );

    vsi_irq_gate u_irq (
        .clk(clk), .rst(rst), .pend_n(pend_n), .mode_n(mode_n), .irq(irq_o)
    );

    assign pend_frm_q = pend_q.frm;
    assign pend_lin_q = pend_q.lin;
    assign line_ie_q  = mode_q.line_ie;
    assign frm_ie_q   = mode_q.frm_ie;

endmodule

// File: rtl/vsi_ctrl_chk.sv
module vsi_ctrl_chk #(
    parameter int LINE_W = 9,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 8,
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              line_adv_i,
    input logic [LINE_W-1:0] line_idx_i,
    input logic              line_evt_i,
    input logic              ovr_evt_i,
    input logic              coll_evt_i,
    input logic              reg_we_i,
    input logic [IDX_W-1:0]  reg_idx_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic              rd_stat_i,
    input logic              ctl_half_i,
    input logic              ctl_clr_i,
    input logic [STAT_W-1:0] status_o,
    input logic              irq_o,
    input logic              ctl_pend_o,
    input logic [LINE_W-1:0] act_h_o,
    input logic              pend_frm_q,
    input logic              pend_lin_q,
    input logic              line_ie_q,
    input logic              frm_ie_q
);

    p_frame_set_r2: assert property (@(posedge clk) disable iff (rst)
        line_adv_i && (line_idx_i == act_h_o) |=> status_o[STAT_W-1] && pend_frm_q);

    p_read_clear_r4: assert property (@(posedge clk) disable iff (rst)
        rd_stat_i && !line_adv_i && !line_evt_i && !ovr_evt_i && !coll_evt_i && !ctl_half_i
        |=> !status_o[STAT_W-1] && !status_o[STAT_W-2] && !irq_o && !ctl_pend_o);

    p_irq_source_r5: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (pend_frm_q && frm_ie_q) || (pend_lin_q && line_ie_q));

    p_regate_on_r6: assert property (@(posedge clk) disable iff (rst)
        reg_we_i && reg_idx_i == '0 && reg_wdata_i[4] && pend_lin_q && !rd_stat_i |=> irq_o);

    p_height_legal_r8: assert property (@(posedge clk) disable iff (rst)
        act_h_o == LINE_W'(192) || act_h_o == LINE_W'(224) || act_h_o == LINE_W'(240));

    p_other_reg_r10: assert property (@(posedge clk) disable iff (rst)
        reg_we_i && reg_idx_i > IDX_W'(1) |=> $stable(act_h_o) && $stable(line_ie_q) && $stable(frm_ie_q));

    p_half_set_r11: assert property (@(posedge clk) disable iff (rst)
        ctl_half_i |=> ctl_pend_o);

endmodule

bind vsi_ctrl vsi_ctrl_chk #(
    .LINE_W(LINE_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .STAT_W(LOW_W + 3)
) u_chk (
    .clk(clk), .rst(rst),
    .line_adv_i(line_adv_i), .line_idx_i(line_idx_i), .line_evt_i(line_evt_i),
    .ovr_evt_i(ovr_evt_i), .coll_evt_i(coll_evt_i),
    .reg_we_i(reg_we_i), .reg_idx_i(reg_idx_i), .reg_wdata_i(reg_wdata_i),
    .rd_stat_i(rd_stat_i), .ctl_half_i(ctl_half_i), .ctl_clr_i(ctl_clr_i),
    .status_o(status_o), .irq_o(irq_o), .ctl_pend_o(ctl_pend_o), .act_h_o(act_h_o),
    .pend_frm_q(pend_frm_q), .pend_lin_q(pend_lin_q),
    .line_ie_q(line_ie_q), .frm_ie_q(frm_ie_q)
);

// File: tb/sim_vsi_ctrl.sv
module sim_vsi_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_adv = 0, line_evt = 0, ovr_evt = 0, coll_evt = 0;
    logic [8:0] line_idx = '0, coll_line = '0;
    logic [7:0] h_pos = '0, coll_x = '0, reg_wdata = '0;
    logic       reg_we = 0, rd_stat = 0, ctl_half = 0, ctl_clr = 0;
    logic [3:0] reg_idx = '0;
    logic [7:0] status;
    logic       irq, ctl_pend;
    logic [8:0] act_h;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    vsi_ctrl u0 (
        .clk(clk), .rst(rst),
        .line_adv_i(line_adv), .line_idx_i(line_idx), .h_pos_i(h_pos),
        .line_evt_i(line_evt), .ovr_evt_i(ovr_evt), .coll_evt_i(coll_evt),
        .coll_line_i(coll_line), .coll_x_i(coll_x),
        .reg_we_i(reg_we), .reg_idx_i(reg_idx), .reg_wdata_i(reg_wdata),
        .rd_stat_i(rd_stat), .ctl_half_i(ctl_half), .ctl_clr_i(ctl_clr),
        .status_o(status), .irq_o(irq), .ctl_pend_o(ctl_pend), .act_h_o(act_h)
    );

    localparam logic [3:0] OP_LINE = 4'd1, OP_LEVT = 4'd2, OP_OVR = 4'd3,
                           OP_W0 = 4'd4, OP_W1 = 4'd5, OP_RD = 4'd6;
    localparam int NV = 14;
    // {op, arg, expected status (before edge for reads, after edge otherwise), expected irq}
    localparam logic [21:0] TBL [0:NV-1] = '{
        {OP_LINE, 9'd100, 8'h1F, 1'b0},
        {OP_LINE, 9'd192, 8'h9F, 1'b0},
        {OP_W1,   9'h020, 8'h9F, 1'b1},
        {OP_W1,   9'h000, 8'h9F, 1'b0},
        {OP_W1,   9'h020, 8'h9F, 1'b1},
        {OP_RD,   9'd0,   8'h9F, 1'b0},
        {OP_LEVT, 9'd0,   8'h1F, 1'b0},
        {OP_W0,   9'h010, 8'h1F, 1'b1},
        {OP_OVR,  9'd0,   8'h5F, 1'b1},
        {OP_RD,   9'd0,   8'h5F, 1'b0},
        {OP_W0,   9'h010, 8'h1F, 1'b0},
        {OP_LINE, 9'd193, 8'h1F, 1'b0},
        {OP_LEVT, 9'd0,   8'h1F, 1'b1},
        {OP_RD,   9'd0,   8'h1F, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // inputs are already set after a falling edge; capture, clock, release pulses
    task automatic tick(output logic [7:0] pre);
        #2 pre = status;
        @(posedge clk);
        #2;
        line_adv = 0; line_evt = 0; ovr_evt = 0; coll_evt = 0;
        reg_we = 0; rd_stat = 0; ctl_half = 0; ctl_clr = 0;
    endtask

    task automatic wreg(input logic [3:0] idx, input logic [7:0] val);
        logic [7:0] pre;
        @(negedge clk);
        reg_we = 1; reg_idx = idx; reg_wdata = val;
        tick(pre);
    endtask

    task automatic do_read(output logic [7:0] pre);
        @(negedge clk);
        rd_stat = 1;
        tick(pre);
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] pre;
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R1 reset state
        check("R1 status", status, 8'h1F);
        check("R1 irq", irq, 0);
        check("R1 ctl", ctl_pend, 0);
        check("R1 height", act_h, 192);

        // table walk: R2 R3 R5 R6 R4
        for (int i = 0; i < NV; i++) begin
            logic [3:0] op;
            logic [8:0] arg;
            op  = TBL[i][21:18];
            arg = TBL[i][17:9];
            @(negedge clk);
            case (op)
                OP_LINE: begin line_adv = 1; line_idx = arg; end
                OP_LEVT: line_evt = 1;
                OP_OVR:  ovr_evt = 1;
                OP_W0:   begin reg_we = 1; reg_idx = 4'd0; reg_wdata = arg[7:0]; end
                OP_W1:   begin reg_we = 1; reg_idx = 4'd1; reg_wdata = arg[7:0]; end
                default: rd_stat = 1;
            endcase
            tick(pre);
            if (op == OP_RD) check("R4 R3 read value", pre, TBL[i][8:1]);
            else             check("R2 R3 R6 status", status, TBL[i][8:1]);
            check("R5 R6 irq", irq, TBL[i][0]);
        end

        // R9 read meets frame event (mode1 bit5=1, mode0 bit4=1, height 192)
        @(negedge clk);
        rd_stat = 1; line_adv = 1; line_idx = 9'd192;
        tick(pre);
        check("R9 returned", pre, 8'h1F);
        check("R9 frame kept", status, 8'h9F);
        check("R9 irq", irq, 1);
        do_read(pre);
        check("R4 cleared", status, 8'h1F);
        check("R4 irq low", irq, 0);
        @(negedge clk);
        rd_stat = 1; line_evt = 1; ovr_evt = 1;
        tick(pre);
        check("R9 line kept irq", irq, 1);
        check("R9 ovr kept", status, 8'h5F);
        do_read(pre);

        // R7 collision deferral
        line_idx = 9'd50; h_pos = 8'd60;
        @(negedge clk);
        coll_evt = 1; coll_line = 9'd50; coll_x = 8'd100;
        tick(pre);
        check("R7 hidden", status, 8'h1F);
        do_read(pre);
        check("R7 read hidden", pre, 8'h1F);
        h_pos = 8'd120;
        #1 check("R7 kept after read", status, 8'h3F);
        do_read(pre);
        check("R7 returned", pre, 8'h3F);
        check("R7 cleared", status, 8'h1F);
        line_idx = 9'd51; h_pos = 8'd10;
        @(negedge clk);
        coll_evt = 1; coll_line = 9'd50; coll_x = 8'd200;
        tick(pre);
        check("R3 coll other line", status, 8'h3F);
        do_read(pre);

        // R8 height decode
        wreg(4'd0, 8'h06);
        wreg(4'd1, 8'h10);
        check("R8 mode B", act_h, 224);
        check("R8 irq off", irq, 0);
        @(negedge clk); line_adv = 1; line_idx = 9'd192; tick(pre);
        check("R2 R8 no frame at 192", status, 8'h1F);
        @(negedge clk); line_adv = 1; line_idx = 9'd224; tick(pre);
        check("R2 R8 frame at 224", status, 8'h9F);
        do_read(pre);
        wreg(4'd1, 8'h08);
        check("R8 mode E", act_h, 240);
        wreg(4'd1, 8'h18);
        check("R8 mode F", act_h, 192);
        wreg(4'd1, 8'h10);

        // R10 other indices ignored
        wreg(4'd2, 8'hFF);
        check("R10 height", act_h, 224);
        wreg(4'd8, 8'h16);
        check("R10 height alias", act_h, 224);
        @(negedge clk); line_evt = 1; tick(pre);
        check("R10 irq stays low", irq, 0);
        wreg(4'd0, 8'h16);
        check("R6 regate after write", irq, 1);
        do_read(pre);

        // R11 half-write flag
        @(negedge clk); ctl_half = 1; tick(pre);
        check("R11 set", ctl_pend, 1);
        @(negedge clk); ctl_clr = 1; tick(pre);
        check("R11 clear", ctl_pend, 0);
        @(negedge clk); ctl_half = 1; tick(pre);
        do_read(pre);
        check("R11 read clears", ctl_pend, 0);
        @(negedge clk); ctl_half = 1; ctl_clr = 1; tick(pre);
        check("R11 set wins", ctl_pend, 1);

        // R1 reset with state present
        @(negedge clk); ovr_evt = 1; line_evt = 1; tick(pre);
        @(negedge clk); rst = 1;
        @(posedge clk); #2 rst = 0;
        check("R1 status again", status, 8'h1F);
        check("R1 irq again", irq, 0);
        check("R1 ctl again", ctl_pend, 0);
        check("R1 height again", act_h, 192);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule